// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block holds the four-state coherence tag (Modified, Exclusive, Shared, Invalid) for every line of a small direct-mapped private cache that sits on a shared, snooped bus. A processor-side request (read, write or evict) is looked up against the line picked by the address index bits. The controller decides whether the request can finish locally or needs a bus transaction: a plain read, a read-for-ownership, a data-less upgrade or a write-back. It then holds the request with a ready/valid handshake until the bus grant arrives.

On the snoop side the controller watches each transaction that another cache drives onto the bus. It reports whether it holds the line, through a shared indication, and whether it must supply dirty data, through a flush indication. It then moves its own copy down the ownership order I, S, E, M to match. Coherence is tracked for whole 64-byte lines only. The data arrays, the replacement choice, memory timing and arbitration between cores belong to the surrounding cache.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. With no request pending, req_ready and bus_req are low. No snoop finds a hit.
- R2: A read whose line is present (tag match, state S, E or M) completes in the same cycle it is presented. It raises no bus_req and leaves the state unchanged.
- R3: A read miss raises bus_req with bus_cmd=1 (read) and the line-aligned address, and holds it until bus_gnt. The request completes in the grant cycle. The line fills to Exclusive if bus_shared_in is low in that cycle, and to Shared if it is high. While bus_req is high, bus_cmd is nonzero.
- R4: A write to a line that is not present issues bus_cmd=2 (read-for-ownership). On grant the line becomes Modified.
- R5: A write to a Shared line issues bus_cmd=3 (upgrade, no data). On grant the line becomes Modified.
- R6: A write to an Exclusive or Modified line completes in the same cycle with no bus transaction and leaves the line Modified.
- R7: Evicting a Modified line issues bus_cmd=4 (write-back) to its address, and the line becomes Invalid on grant. Evicting an Exclusive or Shared line completes at once, with no bus transaction, to Invalid. Evicting an address that is not present completes at once and changes nothing.
- R8: A read or write that misses on an index whose slot holds another tag in Modified first issues bus_cmd=4 for the old line's address. The old line then becomes Invalid without completing the request. The request's own transaction follows.
- R9: A snooped read (snp_cmd=1) that hits raises snp_shared. If the hit line is Modified it also raises snp_flush. The line ends Shared.
- R10: A snooped read-for-ownership (2) or upgrade (3) that hits sends the line to Invalid. It raises snp_flush if the line was Modified and never raises snp_shared.
- R11: A snooped write-back (4), or any snoop whose tag does not match, raises neither output and changes no state.
- R12: Address bits below the 64-byte line boundary never affect hits. bus_addr always has them at zero.
- R13: In any cycle where a snoop targets the same index as a pending request, the request neither completes nor raises bus_req. It is re-evaluated in the next cycle, so an upgrade whose Shared copy was just invalidated becomes a read-for-ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_op | input | 2 | 0 read, 1 write, 2 evict |
| req_addr | input | ADDR_W | Processor byte address |
| req_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Asking for the bus |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-for-ownership, 3 upgrade, 4 write-back |
| bus_addr | output | ADDR_W | Line-aligned address of the transaction |
| bus_gnt | input | 1 | Transaction granted and performed this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (sampled at read grant) |
| snp_valid | input | 1 | Foreign transaction on the bus |
| snp_cmd | input | 3 | Foreign command, same coding as bus_cmd |
| snp_addr | input | ADDR_W | Foreign transaction address |
| snp_shared | output | 1 | This cache holds the snooped line (read snoop) |
| snp_flush | output | 1 | This cache must supply its dirty copy |

## Verification
The in-RTL properties rely on two promises from the environment. The first is that a request, once presented, stays asserted with the same operation and address until req_ready. The second is that bus_gnt never arrives in a cycle where a foreign snoop is on the bus, since the bus carries one transaction at a time. The bench honours both. It drives each request from a task that changes its inputs only after req_ready has been seen. It raises the grant only while bus_req is high, and places its snoops at cycle offsets that are chosen so they never meet a grant.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_t;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2, OP_RSV = 2'd3} pop_t;
  typedef enum logic [2:0] {
    BC_NONE = 3'd0, BC_RD = 3'd1, BC_RDX = 3'd2, BC_UPG = 3'd3, BC_WB = 3'd4
  } bcmd_t;

  // Bus transaction a processor request needs. On a miss, st is the state of
  // whatever other tag sits in the slot.
  function automatic bcmd_t need_cmd(pop_t op, logic hit, mesi_t st);
    bcmd_t c;
    case (op)
      OP_EV:   c = (hit && st == ST_M) ? BC_WB : BC_NONE;
      OP_WR:   c = hit ? ((st == ST_S) ? BC_UPG : BC_NONE)
                       : ((st == ST_M) ? BC_WB : BC_RDX);
      default: c = hit ? BC_NONE : ((st == ST_M) ? BC_WB : BC_RD);
    endcase
    return c;
  endfunction

  // State the requested line holds once the request completes.
  function automatic mesi_t done_state(pop_t op, logic hit, mesi_t st, logic shared_in);
    mesi_t n;
    case (op)
      OP_EV:   n = ST_I;
      OP_WR:   n = ST_M;
      default: n = hit ? st : (shared_in ? ST_S : ST_E);
    endcase
    return n;
  endfunction

  function automatic logic snoop_acts(bcmd_t c);
    return (c == BC_RD) || (c == BC_RDX) || (c == BC_UPG);
  endfunction

  function automatic mesi_t snoop_next(mesi_t cur, bcmd_t c);
    mesi_t n;
    case (c)
      BC_RD:          n = (cur == ST_I) ? ST_I : ST_S;
      BC_RDX, BC_UPG: n = ST_I;
      default:        n = cur;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 22,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [IDX_W-1:0]             ra_idx,
  output mesi_t                        ra_st,
  output logic [TAG_W-1:0]             ra_tag,
  input  logic [IDX_W-1:0]             rb_idx,
  output mesi_t                        rb_st,
  output logic [TAG_W-1:0]             rb_tag,
  input  logic                         lw_en,
  input  logic [IDX_W-1:0]             lw_idx,
  input  mesi_t                        lw_st,
  input  logic [TAG_W-1:0]             lw_tag,
  input  logic                         sw_en,
  input  logic [IDX_W-1:0]             sw_idx,
  input  mesi_t                        sw_st,
  output logic [LINES-1:0][1:0]        st_vec
);

  logic [TAG_W-1:0] tag_all [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    mesi_t            st_r;
    logic [TAG_W-1:0] tag_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= ST_I;
        tag_r <= '0;
      end else if (lw_en && lw_idx == IDX_W'(g)) begin
        st_r  <= lw_st;
        tag_r <= lw_tag;
      end else if (sw_en && sw_idx == IDX_W'(g)) begin
        st_r  <= sw_st;
      end
    end
    assign st_vec[g]  = st_r;
    assign tag_all[g] = tag_r;
  end

  assign ra_st  = mesi_t'(st_vec[ra_idx]);
  assign ra_tag = tag_all[ra_idx];
  assign rb_st  = mesi_t'(st_vec[rb_idx]);
  assign rb_tag = tag_all[rb_idx];

  // R13: the two update paths never land on one slot in one cycle
  a_r13_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(lw_en && sw_en && lw_idx == sw_idx));

endmodule

// File: rtl/mesi_req_decode.sv
module mesi_req_decode
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 22,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 6,
  parameter int ADDR_W = TAG_W + IDX_W + OFF_W
) (
  input  pop_t              op,
  input  logic [TAG_W-1:0]  rtag,
  input  logic [IDX_W-1:0]  ridx,
  input  mesi_t             slot_st,
  input  logic [TAG_W-1:0]  slot_tag,
  input  logic              shared_in,
  output logic              hit,
  output bcmd_t             cmd,
  output logic              victim,
  output logic              touch,
  output mesi_t             fin_st,
  output logic [ADDR_W-1:0] line_addr
);

  assign hit       = (slot_st != ST_I) && (slot_tag == rtag);
  assign cmd       = need_cmd(op, hit, slot_st);
  assign victim    = (cmd == BC_WB) && !hit;
  assign touch     = !(op == OP_EV && !hit);
  assign fin_st    = victim ? ST_I : done_state(op, hit, slot_st, shared_in);
  assign line_addr = {(victim ? slot_tag : rtag), ridx, {OFF_W{1'b0}}};

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int TAG_W = 22
) (
  input  logic             valid,
  input  bcmd_t            cmd,
  input  logic [TAG_W-1:0] stag,
  input  mesi_t            slot_st,
  input  logic [TAG_W-1:0] slot_tag,
  output logic             hit,
  output logic             upd_en,
  output mesi_t            new_st,
  output logic             flush,
  output logic             shared
);

  assign hit    = valid && (slot_st != ST_I) && (slot_tag == stag);
  assign upd_en = hit && snoop_acts(cmd);
  assign new_st = snoop_next(slot_st, cmd);
  assign flush  = upd_en && (slot_st == ST_M);
  assign shared = hit && (cmd == BC_RD);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              bus_req,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_flush
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [IDX_W-1:0] req_idx, snp_idx;
  logic [TAG_W-1:0] req_tag, snp_tag;
  assign req_idx = req_addr[OFF_W +: IDX_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign snp_idx = snp_addr[OFF_W +: IDX_W];
  assign snp_tag = snp_addr[ADDR_W-1 -: TAG_W];

  logic unused_offsets;
  assign unused_offsets = ^{req_addr[OFF_W-1:0], snp_addr[OFF_W-1:0]};

  // named internal events
  mesi_t            slot_st, sslot_st, dec_fin, snp_new;
  logic [TAG_W-1:0] slot_tag, sslot_tag;
  logic             dec_hit, dec_victim, dec_touch;
  bcmd_t            dec_cmd;
  logic [ADDR_W-1:0] dec_addr;
  logic             snp_hit, snp_upd;
  logic             stall, go, loc_we;
  logic [LINES-1:0][1:0] st_vec;

  mesi_state_array #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_arr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ra_idx (req_idx),
    .ra_st  (slot_st),
    .ra_tag (slot_tag),
    .rb_idx (snp_idx),
    .rb_st  (sslot_st),
    .rb_tag (sslot_tag),
    .lw_en  (loc_we),
    .lw_idx (req_idx),
    .lw_st  (dec_fin),
    .lw_tag (dec_victim ? slot_tag : req_tag),
    .sw_en  (snp_upd),
    .sw_idx (snp_idx),
    .sw_st  (snp_new),
    .st_vec (st_vec)
  );

  mesi_req_decode #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_dec (
    .op        (pop_t'(req_op)),
    .rtag      (req_tag),
    .ridx      (req_idx),
    .slot_st   (slot_st),
    .slot_tag  (slot_tag),
    .shared_in (bus_shared_in),
    .hit       (dec_hit),
    .cmd       (dec_cmd),
    .victim    (dec_victim),
    .touch     (dec_touch),
    .fin_st    (dec_fin),
    .line_addr (dec_addr)
  );

  mesi_snoop_resp #(.TAG_W(TAG_W)) u_snp (
    .valid    (snp_valid),
    .cmd      (bcmd_t'(snp_cmd)),
    .stag     (snp_tag),
    .slot_st  (sslot_st),
    .slot_tag (sslot_tag),
    .hit      (snp_hit),
    .upd_en   (snp_upd),
    .new_st   (snp_new),
    .flush    (snp_flush),
    .shared   (snp_shared)
  );

  assign stall     = req_valid && snp_valid && (snp_idx == req_idx);
  assign go        = req_valid && !stall;
  assign bus_req   = go && (dec_cmd != BC_NONE);
  assign bus_cmd   = bus_req ? dec_cmd : BC_NONE;
  assign bus_addr  = bus_req ? dec_addr : '0;
  assign req_ready = go && ((dec_cmd == BC_NONE) || (bus_gnt && !dec_victim));
  assign loc_we    = go && dec_touch && ((dec_cmd == BC_NONE) || bus_gnt);

  // ---- environment promises (see brief) ----
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_op)));
  a_r13_no_gnt_in_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_gnt && snp_valid));

  // ---- behaviour ----
  a_r3_req_has_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (req_valid && bus_cmd != 3'd0 && bus_cmd <= 3'd4));
  a_r12_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_addr[OFF_W-1:0] == '0));
  a_r13_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && snp_valid && snp_addr[OFF_W +: IDX_W] == req_addr[OFF_W +: IDX_W])
      |-> (!req_ready && !bus_req));
  a_r9_flush_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> (snp_valid && snp_cmd != 3'd4 && snp_cmd != 3'd0));
  a_r10_shared_on_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared |-> (snp_valid && snp_cmd == 3'd1));
  a_r6_write_owns: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd1) |=> (st_vec[$past(req_idx)] == ST_M));
  a_r7_evict_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd2 && dec_hit) |=> (st_vec[$past(req_idx)] == ST_I));
  a_r10_snoop_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && (snp_cmd == 3'd2 || snp_cmd == 3'd3)) |=> (st_vec[$past(snp_idx)] == ST_I));

endmodule

// File: tb/sim_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_snoop_ctrl;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [1:0]  req_op = 0;
  logic [31:0] req_addr = 0;
  logic        req_ready;
  logic        bus_req;
  logic [2:0]  bus_cmd;
  logic [31:0] bus_addr;
  logic        bus_gnt = 0;
  logic        bus_shared_in = 0;
  logic        snp_valid = 0;
  logic [2:0]  snp_cmd = 0;
  logic [31:0] snp_addr = 0;
  logic        snp_shared;
  logic        snp_flush;

  always #2.5 clk = ~clk;

  mesi_snoop_ctrl u0 (.*);

  int n_chk = 0;
  int n_err = 0;
  string cur_tag = "R1";

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] A(input int tag, input int idx, input int off);
    return (32'(tag) << 10) | (32'(idx) << 6) | 32'(off);
  endfunction

  // ---------------- behavioural reference model ----------------
  int          mst  [16];   // 0 I, 1 S, 2 E, 3 M
  logic [21:0] mtag [16];
  logic        e_rdy, e_breq, e_sh, e_fl, e_sact, e_lwe, m_victim;
  logic [2:0]  e_cmd;
  logic [31:0] e_addr;
  int          e_lst;

  always_comb begin
    int si, ri, cur, c;
    logic shit, rhit, stl, go;
    si   = int'(snp_addr[9:6]);
    ri   = int'(req_addr[9:6]);
    shit = snp_valid && mst[si] != 0 && mtag[si] == snp_addr[31:10];
    e_sact = shit && snp_cmd >= 3'd1 && snp_cmd <= 3'd3;
    e_sh   = shit && snp_cmd == 3'd1;
    e_fl   = e_sact && mst[si] == 3;
    stl  = req_valid && snp_valid && si == ri;
    cur  = mst[ri];
    rhit = cur != 0 && mtag[ri] == req_addr[31:10];
    if (req_op == 2'd2)      c = (rhit && cur == 3) ? 4 : 0;
    else if (req_op == 2'd1) c = rhit ? ((cur == 1) ? 3 : 0) : ((cur == 3) ? 4 : 2);
    else                     c = rhit ? 0 : ((cur == 3) ? 4 : 1);
    m_victim = (c == 4) && !rhit;
    go     = req_valid && !stl;
    e_breq = go && c != 0;
    e_cmd  = e_breq ? 3'(c) : 3'd0;
    e_addr = e_breq ? {(m_victim ? mtag[ri] : req_addr[31:10]), req_addr[9:6], 6'd0} : 32'd0;
    e_rdy  = go && (c == 0 || (bus_gnt && !m_victim));
    e_lwe  = go && (c == 0 || bus_gnt) && !(req_op == 2'd2 && !rhit);
    if (m_victim || req_op == 2'd2) e_lst = 0;
    else if (req_op == 2'd1)        e_lst = 3;
    else if (rhit)                  e_lst = cur;
    else                            e_lst = bus_shared_in ? 1 : 2;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin mst[i] <= 0; mtag[i] <= '0; end
    end else begin
      if (e_sact) mst[snp_addr[9:6]] <= (snp_cmd == 3'd1) ? 1 : 0;
      if (e_lwe) begin
        mst[req_addr[9:6]] <= e_lst;
        if (!m_victim) mtag[req_addr[9:6]] <= req_addr[31:10];
      end
    end
  end

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk({req_ready, bus_req, bus_cmd, bus_addr, snp_shared, snp_flush} ===
          {e_rdy, e_breq, e_cmd, e_addr, e_sh, e_fl}, cur_tag, "cycle outputs",
          {26'd0, req_ready, bus_req, bus_cmd, bus_addr, snp_shared, snp_flush},
          {26'd0, e_rdy, e_breq, e_cmd, e_addr, e_sh, e_fl});
    end
  end

  // ---------------- stimulus tasks ----------------
  int          g_n;
  logic [2:0]  g_cmd0, g_cmd1;
  logic [31:0] g_addr0;
  logic        g_saw_req;

  task automatic do_req(input logic [1:0] op, input logic [31:0] addr,
                        input int dly, input logic shin);
    int cnt = 0;
    logic rdy, br, g;
    g_n = 0; g_cmd0 = 0; g_cmd1 = 0; g_addr0 = 0; g_saw_req = 0;
    @(posedge clk); #1;
    req_valid = 1; req_op = op; req_addr = addr; bus_shared_in = shin; bus_gnt = 0;
    forever begin
      @(negedge clk);
      rdy = req_ready; br = bus_req; g = bus_gnt;
      if (br) g_saw_req = 1;
      if (br && g) begin
        if (g_n == 0) begin g_cmd0 = bus_cmd; g_addr0 = bus_addr; end
        else g_cmd1 = bus_cmd;
        g_n++;
      end
      @(posedge clk); #1;
      if (rdy) begin req_valid = 0; bus_gnt = 0; break; end
      if (bus_gnt) begin bus_gnt = 0; cnt = 0; end
      else if (br) begin
        if (cnt >= dly) bus_gnt = 1;
        else cnt++;
      end
    end
  endtask

  task automatic snoop(input logic [2:0] cmd, input logic [31:0] addr,
                       input logic exp_sh, input logic exp_fl, input string tag);
    @(posedge clk); #1;
    snp_valid = 1; snp_cmd = cmd; snp_addr = addr;
    @(negedge clk);
    chk(snp_shared === exp_sh, tag, "snp_shared", 64'(snp_shared), 64'(exp_sh));
    chk(snp_flush === exp_fl, tag, "snp_flush", 64'(snp_flush), 64'(exp_fl));
    @(posedge clk); #1;
    snp_valid = 0; snp_cmd = 0; snp_addr = 0;
  endtask

  // ---------------- scenarios ----------------
  logic finished = 0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    cur_tag = "R1";
    chk(req_ready === 1'b0 && bus_req === 1'b0, "R1", "idle outputs",
        64'({req_ready, bus_req}), 64'd0);
    snoop(3'd1, A(1, 2, 0), 0, 0, "R1");

    cur_tag = "R3";
    do_req(2'd0, A(1, 2, 0), 2, 0);
    chk(g_cmd0 == 3'd1, "R3", "read miss cmd", 64'(g_cmd0), 64'd1);
    chk(g_addr0 == A(1, 2, 0), "R3", "read miss addr", 64'(g_addr0), 64'(A(1, 2, 0)));

    cur_tag = "R2";
    do_req(2'd0, A(1, 2, 5), 0, 0);
    chk(!g_saw_req, "R2", "read hit bus use (R12 offset)", 64'(g_saw_req), 64'd0);

    cur_tag = "R6";
    do_req(2'd1, A(1, 2, 9), 0, 0);
    chk(!g_saw_req, "R6", "write on E bus use", 64'(g_saw_req), 64'd0);

    cur_tag = "R9";
    snoop(3'd1, A(1, 2, 0), 1, 1, "R9");

    cur_tag = "R5";
    do_req(2'd1, A(1, 2, 0), 1, 0);
    chk(g_cmd0 == 3'd3, "R5", "write on S cmd", 64'(g_cmd0), 64'd3);

    cur_tag = "R7";
    do_req(2'd2, A(1, 2, 0), 1, 0);
    chk(g_cmd0 == 3'd4, "R7", "evict M cmd", 64'(g_cmd0), 64'd4);
    chk(g_addr0 == A(1, 2, 0), "R7", "evict M addr", 64'(g_addr0), 64'(A(1, 2, 0)));
    do_req(2'd0, A(1, 2, 0), 0, 0);
    chk(g_cmd0 == 3'd1, "R7", "line gone after evict", 64'(g_cmd0), 64'd1);

    cur_tag = "R3";
    do_req(2'd0, A(2, 3, 0), 0, 1);
    snoop(3'd1, A(2, 3, 7), 1, 0, "R3");
    cur_tag = "R10";
    snoop(3'd2, A(2, 3, 0), 0, 0, "R10");
    cur_tag = "R4";
    do_req(2'd1, A(2, 3, 0), 2, 0);
    chk(g_cmd0 == 3'd2, "R4", "write on I cmd", 64'(g_cmd0), 64'd2);

    cur_tag = "R8";
    do_req(2'd0, A(5, 3, 0), 1, 0);
    chk(g_n == 2, "R8", "grant count", 64'(g_n), 64'd2);
    chk(g_cmd0 == 3'd4, "R8", "victim cmd", 64'(g_cmd0), 64'd4);
    chk(g_addr0 == A(2, 3, 0), "R8", "victim addr", 64'(g_addr0), 64'(A(2, 3, 0)));
    chk(g_cmd1 == 3'd1, "R8", "follow-up cmd", 64'(g_cmd1), 64'd1);

    cur_tag = "R7";
    do_req(2'd2, A(5, 3, 0), 0, 0);
    chk(!g_saw_req, "R7", "evict E bus use", 64'(g_saw_req), 64'd0);
    snoop(3'd1, A(5, 3, 0), 0, 0, "R7");
    do_req(2'd2, A(9, 3, 0), 0, 0);
    chk(!g_saw_req, "R7", "evict miss bus use", 64'(g_saw_req), 64'd0);

    cur_tag = "R11";
    do_req(2'd0, A(6, 7, 0), 0, 0);
    snoop(3'd4, A(6, 7, 0), 0, 0, "R11");
    snoop(3'd2, A(8, 7, 0), 0, 0, "R11");
    do_req(2'd0, A(6, 7, 0), 0, 0);
    chk(!g_saw_req, "R11", "line kept after ignored snoops", 64'(g_saw_req), 64'd0);

    cur_tag = "R12";
    do_req(2'd1, A(6, 7, 63), 0, 0);
    chk(!g_saw_req, "R12", "write E at line end", 64'(g_saw_req), 64'd0);
    snoop(3'd1, A(6, 7, 1), 1, 1, "R12");

    cur_tag = "R13";
    do_req(2'd0, A(4, 5, 0), 0, 1);
    fork
      do_req(2'd1, A(4, 5, 0), 4, 0);
      begin @(posedge clk); snoop(3'd3, A(4, 5, 0), 0, 0, "R13"); end
    join
    chk(g_cmd0 == 3'd2, "R13", "re-evaluated cmd", 64'(g_cmd0), 64'd2);

    cur_tag = "R10";
    snoop(3'd2, A(4, 5, 0), 0, 1, "R10");
    snoop(3'd1, A(4, 5, 0), 0, 0, "R10");

    repeat (2) @(posedge clk);
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (R1-R13 run) expired: actual %0d cycles expected completion", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule